// File: doc/BRIEF.md
# Programmable Serial Clock Waveform Generator

This block produces the serial clock for a flash command sequencer, together with the strobes that tell the sequencer when to present the next output bit and when to capture an input bit. A 20-bit timing word sets the shape of one clock period. It holds the period length in system clocks, and the counts inside that period at which the clock rises, at which it falls, and at which read data is sampled. Because each of these points is programmed on its own, the generator can produce clocks with a duty cycle other than 50%. It can also move the sample point away from the clock edges, which helps with slow board paths.

The sequencer raises `run_req` to start the clock. It counts bits with the `period_end` pulse and drops `run_req` when the access is done. The generator then completes the period in progress and parks the clock high, which matches SPI mode 3. A typical setting uses a period of 2N with the falling edge at 0 and the rising edge at N. This gives a square wave at the system clock divided by 2N.

Top module: `sck_wavegen`

## Requirements
- R1: After reset, and whenever no period is running, `sck` is 1 and `shift_stb`, `sample_stb` and `period_end` are 0.
- R2: When `run_req` is 1 while idle, the first period starts in the next cycle, at count 0.
- R3: A period lasts P system clocks, counting 0 to P-1. P is `timing[3:0]`, except that a value of 0 or 1 is taken as 2. `period_end` is 1 on count P-1 only.
- R4: In the cycle after the count equals the falling position `timing[15:12]`, `sck` is 0.
- R5: In the cycle after the count equals the rising position `timing[11:8]`, `sck` is 1. When the rising and falling positions are equal, the rise wins.
- R6: `shift_stb` is 1 for exactly the cycle in which the count equals the falling position.
- R7: `sample_stb` is 1 for exactly the cycle in which the count equals the read position `timing[19:16]`.
- R8: A position at or beyond P never matches. It causes no edge and no strobe.
- R9: The generator checks `run_req` on the last count of each period. If `run_req` is 1, the next period starts at once at count 0. If it is 0, the generator goes idle and `sck` is 1 in the following cycle, whatever the edge positions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Run request from the sequencer |
| timing | input | 20 | Period [3:0], rise [11:8], fall [15:12], read [19:16] |
| sck | output | 1 | Serial clock, registered, idles high |
| shift_stb | output | 1 | Present the next output bit |
| sample_stb | output | 1 | Capture the input bit |
| period_end | output | 1 | Last system clock of a period |

## Verification
The assertions assume that `timing` holds still while a period is running. If it changed mid-period, the count could sit beyond the new last count, and the edge checks would no longer describe a meaningful waveform. The bench therefore loads each timing word only while the generator is idle, after a dropped request has let the current period finish. It then compares every cycle against a model built from the requirements. The stimulus covers the clamped periods, rise and fall at the same position, positions beyond the period, and a request that lasts a single cycle.

// File: rtl/sck_wavegen.sv
module sck_wavegen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_req,
  input  logic [19:0] timing,
  output logic        sck,
  output logic        shift_stb,
  output logic        sample_stb,
  output logic        period_end
);
  logic [3:0] per_f, rise_f, fall_f, rd_f, last;
  logic [3:0] cnt;
  logic       active;

  assign per_f  = timing[3:0];
  assign rise_f = timing[11:8];
  assign fall_f = timing[15:12];
  assign rd_f   = timing[19:16];
  assign last   = (per_f < 4'd2) ? 4'd1 : per_f - 4'd1;

  assign period_end = active && (cnt == last);
  assign shift_stb  = active && (cnt == fall_f);
  assign sample_stb = active && (cnt == rd_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= 4'd0;
      sck    <= 1'b1;
    end else if (!active) begin
      active <= run_req;
      cnt    <= 4'd0;
      sck    <= 1'b1;
    end else begin
      cnt <= period_end ? 4'd0 : cnt + 4'd1;
      if (period_end) active <= run_req;
      if (period_end && !run_req) sck <= 1'b1;
      else if (cnt == rise_f)     sck <= 1'b1;
      else if (cnt == fall_f)     sck <= 1'b0;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sck);

  assert_start_count0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && run_req) |=> (active && cnt == 4'd0));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && run_req) |=> (active && cnt == 4'd0));

  assert_fall_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && rise_f != fall_f && !(period_end && !run_req)) |=> !sck);

  assert_rise_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == rise_f) |=> sck);

  assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !run_req) |=> (!active && sck));
endmodule

// File: tb/sck_wavegen_bench.sv
module sck_wavegen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_req = 1'b0;
  logic [19:0] timing = 20'h0;
  logic        sck, shift_stb, sample_stb, period_end;

  int vectors = 0;
  int errors  = 0;

  bit m_act = 1'b0;
  int m_cnt = 0;
  bit m_sck = 1'b1;

  always #2 clk = ~clk;

  sck_wavegen u_sck_wavegen (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .timing(timing),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .period_end(period_end)
  );

  function automatic int eff_per();
    int p = int'(timing[3:0]);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic check_bit(input string req, input string nm, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  // Compare the current outputs with the model, then apply run_v for the next edge.
  task automatic tick(input bit run_v);
    int last;
    @(negedge clk);
    last = eff_per() - 1;
    check_bit("R4,R5", "sck", sck, m_sck);
    check_bit("R6", "shift_stb", shift_stb, m_act && m_cnt == int'(timing[15:12]));
    check_bit("R7", "sample_stb", sample_stb, m_act && m_cnt == int'(timing[19:16]));
    check_bit("R3", "period_end", period_end, m_act && m_cnt == last);
    run_req = run_v;
    if (!m_act) begin
      m_act = run_v;
      m_cnt = 0;
      m_sck = 1'b1;
    end else begin
      if (m_cnt == last && !run_v) m_sck = 1'b1;
      else if (m_cnt == int'(timing[11:8])) m_sck = 1'b1;
      else if (m_cnt == int'(timing[15:12])) m_sck = 1'b0;
      if (m_cnt == last) begin
        m_act = run_v;
        m_cnt = 0;
      end else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic run_periods(input logic [19:0] tw, input int cycles);
    timing = tw;
    for (int i = 0; i < cycles; i++) tick(1'b1);
    for (int i = 0; i < 20; i++) tick(1'b0);
    // R9: the model is idle again after the drop and the final period
    vectors++;
    if (m_act) begin
      errors++;
      $display("FAIL R9 model still running: got 1 expected 0");
    end
  endtask

  task automatic t_reset();
    // R1: idle outputs after reset
    check_bit("R1", "sck", sck, 1'b1);
    check_bit("R1", "shift_stb", shift_stb, 1'b0);
    check_bit("R1", "sample_stb", sample_stb, 1'b0);
    check_bit("R1", "period_end", period_end, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0);
  endtask

  // R2, R3, R4, R5: square wave, period 4, fall 0, rise 2, read 2
  task automatic t_square(); run_periods(20'h2_0_2_04, 13); endtask
  // R3: period fields 0 and 1 clamp to 2
  task automatic t_clamp0(); run_periods(20'h1_0_1_00, 9); endtask
  task automatic t_clamp1(); run_periods(20'h0_0_1_01, 7); endtask
  // R4, R5, R7: skewed duty, period 7, fall 1, rise 5, read 6
  task automatic t_skew(); run_periods(20'h6_1_5_07, 22); endtask
  // R5: rise and fall equal, rise wins
  task automatic t_equal(); run_periods(20'h2_3_3_06, 15); endtask
  // R8: read 9 and rise 15 lie beyond period 5
  task automatic t_range(); run_periods(20'h9_1_F_05, 16); endtask
  // R9: a one-cycle request still gives one full period, then park
  task automatic t_pulse(); run_periods(20'h4_2_6_09, 1); endtask
  // R9: drop mid-period, with period 15
  task automatic t_drop(); run_periods(20'hE_4_A_0F, 23); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_square();
    t_clamp0();
    t_clamp1();
    t_skew();
    t_equal();
    t_range();
    t_pulse();
    t_drop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule